// File: doc/BRIEF.md
# Fast System Call Transition Unit

This block carries out the architectural state change for three privileged-transition operations: the fast call from user code into the kernel, the matching fast return, and the exchange of the two GS base values. A decoder presents one operation strobe together with the live register values. The block then produces the next instruction pointer, flags, code and stack selectors, the privilege level, and the values destined for the two scratch registers. It also produces either a completion pulse or a fault with its vector number.

On entry, the kernel address and the flag mask come from configuration inputs. On exit, the saved return address and saved flags come back with interrupts re-enabled. A return to a non-canonical address is refused before any selector or privilege state moves. The privilege level is held inside the block and starts at kernel level. All results are registered. They appear in the cycle after the strobe, and a faulting operation leaves every output register as it was.

Top module: `syscall_xfer_unit`

## Requirements
- R1: With bit 8 of `ext_feat_i` clear, a call (`op_kind_i`=0) or return (`op_kind_i`=1) raises `fault_o` with `fault_vec_o`=6 and changes no state. The reserved code 3 raises the same fault regardless of that bit.
- R2: A completed call writes `next_ip_i` to `rcx_wr_o` and `flags_i` to `r11_wr_o`, and it pulses `scratch_we_o` for that cycle.
- R3: A completed call loads `ip_o` from `entry_addr_i` and sets `flags_o` = `flags_i` AND NOT `flag_mask_i`.
- R4: A completed call sets `cs_o` to `sel_cfg_i[47:32]`, `ss_o` to that value plus 8, and `cpl_o` to 0.
- R5: A completed return sets `ip_o` to `rcx_i` and `flags_o` to `r11_i` with bit 9 forced to 1.
- R6: A completed return sets `cs_o` to `sel_cfg_i[63:48]`, `ss_o` to that value plus 8, and `cpl_o` to 3.
- R7: A return whose `rcx_i` bits [63:47] are not all equal raises `fault_o` with `fault_vec_o`=13, and selectors, privilege, pointer and flags keep their values.
- R8: A swap (`op_kind_i`=2) at privilege 0 completes in one cycle with `gs_base_o`=`kgs_base_i` and `kgs_base_o`=`gs_base_i`.
- R9: A swap or a return issued at privilege 3 raises `fault_o` with `fault_vec_o`=13 and changes no state.
- R10: Every strobe is answered exactly one cycle later by exactly one of `done_o` or `fault_o`. Neither is asserted without a strobe. `fault_vec_o` is 0 whenever `fault_o` is low.
- R11: After reset all data outputs are 0, `cpl_o` is 0, and `done_o`, `fault_o` and `scratch_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation strobe |
| op_kind_i | input | 2 | 0 call, 1 return, 2 GS swap, 3 reserved |
| next_ip_i | input | 64 | Address of the instruction after the current one |
| flags_i | input | 64 | Current flags register |
| rcx_i | input | 64 | Return-address register value |
| r11_i | input | 64 | Saved-flags register value |
| ext_feat_i | input | 64 | Extended feature enable register; bit 8 enables call/return |
| sel_cfg_i | input | 64 | Selector register; [47:32] kernel code, [63:48] user code |
| entry_addr_i | input | 64 | Kernel entry address |
| flag_mask_i | input | 64 | Flags cleared on entry |
| gs_base_i | input | 64 | Current GS base |
| kgs_base_i | input | 64 | Current kernel GS base |
| ip_o | output | 64 | New instruction pointer |
| flags_o | output | 64 | New flags |
| cs_o | output | 16 | New code selector |
| ss_o | output | 16 | New stack selector |
| cpl_o | output | 2 | Current privilege level |
| rcx_wr_o | output | 64 | Value for the return-address register |
| r11_wr_o | output | 64 | Value for the saved-flags register |
| scratch_we_o | output | 1 | Write strobe for both scratch registers |
| gs_base_o | output | 64 | New GS base |
| kgs_base_o | output | 64 | New kernel GS base |
| done_o | output | 1 | Operation completed |
| fault_o | output | 1 | Operation faulted |
| fault_vec_o | output | 8 | Fault vector: 6 invalid opcode, 13 protection |

## Verification
Every result is due on the clock edge after the strobe, with a single register stage between inputs and outputs. The driver applies each operation on a falling edge and pushes the expected result into a queue. The monitor samples two nanoseconds after each rising edge and pops exactly one item for the edge that follows a strobe, so a result that came early or late shows up as a mismatch. On edges with no strobe pending, the monitor checks that neither completion nor fault is raised. Faulting cases compare the full output set with the values left by the previous completed operation, which confirms at the ports that nothing moved.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

    typedef enum logic [1:0] {
        OP_CALL = 2'd0,
        OP_RET  = 2'd1,
        OP_SWAP = 2'd2,
        OP_RSVD = 2'd3
    } sxu_op_e;

    localparam logic [7:0] VEC_INV_OP = 8'd6;
    localparam logic [7:0] VEC_PROT   = 8'd13;

    localparam logic [1:0] CPL_KERN = 2'd0;
    localparam logic [1:0] CPL_USER = 2'd3;

endpackage

// File: rtl/sxu_canon_chk.sv
module sxu_canon_chk #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic [ADDR_W-VA_BITS:0] addr_hi,
    output logic                    canon_ok
);
    // addr_hi carries bits [ADDR_W-1:VA_BITS-1]; canonical when all equal
    assign canon_ok = (&addr_hi) | ~(|addr_hi);
endmodule

// File: rtl/sxu_flag_xform.sv
module sxu_flag_xform #(
    parameter int ADDR_W = 64,
    parameter int IF_BIT = 9
) (
    input  logic [ADDR_W-1:0] cur_flags,
    input  logic [ADDR_W-1:0] entry_mask,
    input  logic [ADDR_W-1:0] saved_flags,
    output logic [ADDR_W-1:0] entry_flags,
    output logic [ADDR_W-1:0] exit_flags
);
    localparam logic [ADDR_W-1:0] FORCE_SET = ADDR_W'(1) << IF_BIT;

    assign entry_flags = cur_flags & ~entry_mask;
    assign exit_flags  = saved_flags | FORCE_SET;
endmodule

// File: rtl/sxu_sel_pick.sv
module sxu_sel_pick #(
    parameter int SEL_W   = 16,
    parameter int SS_STEP = 8
) (
    input  logic [2*SEL_W-1:0]        sel_hi,
    output logic [1:0][SEL_W-1:0]     code_sel,
    output logic [1:0][SEL_W-1:0]     stk_sel
);
    // index 0: kernel field, index 1: user field
    for (genvar g = 0; g < 2; g++) begin : g_field
        localparam int LSB = g * SEL_W;
        assign code_sel[g] = sel_hi[LSB +: SEL_W];
        assign stk_sel[g]  = sel_hi[LSB +: SEL_W] + SEL_W'(SS_STEP);
    end
endmodule

// File: rtl/syscall_xfer_unit.sv
module syscall_xfer_unit
    import sxu_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48,
    parameter int SEL_W   = 16,
    parameter int SS_STEP = 8,
    parameter int EN_BIT  = 8,
    parameter int IF_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [1:0]        op_kind_i,
    input  logic [ADDR_W-1:0] next_ip_i,
    input  logic [ADDR_W-1:0] flags_i,
    input  logic [ADDR_W-1:0] rcx_i,
    input  logic [ADDR_W-1:0] r11_i,
    input  logic [ADDR_W-1:0] ext_feat_i,
    input  logic [4*SEL_W-1:0] sel_cfg_i,
    input  logic [ADDR_W-1:0] entry_addr_i,
    input  logic [ADDR_W-1:0] flag_mask_i,
    input  logic [ADDR_W-1:0] gs_base_i,
    input  logic [ADDR_W-1:0] kgs_base_i,
    output logic [ADDR_W-1:0] ip_o,
    output logic [ADDR_W-1:0] flags_o,
    output logic [SEL_W-1:0]  cs_o,
    output logic [SEL_W-1:0]  ss_o,
    output logic [1:0]        cpl_o,
    output logic [ADDR_W-1:0] rcx_wr_o,
    output logic [ADDR_W-1:0] r11_wr_o,
    output logic              scratch_we_o,
    output logic [ADDR_W-1:0] gs_base_o,
    output logic [ADDR_W-1:0] kgs_base_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [7:0]        fault_vec_o
);

    localparam int CFG_W = 4 * SEL_W;

    typedef struct packed {
        logic [ADDR_W-1:0] ip;
        logic [ADDR_W-1:0] flags;
        logic [ADDR_W-1:0] rcx_val;
        logic [ADDR_W-1:0] r11_val;
        logic [ADDR_W-1:0] gs;
        logic [ADDR_W-1:0] kgs;
        logic [SEL_W-1:0]  cs;
        logic [SEL_W-1:0]  ss;
        logic [1:0]        cpl;
        logic              we;
        logic              done;
        logic              fault;
        logic [7:0]        vec;
    } xfer_st_t;

    xfer_st_t st_d, st_q;

    logic                    sce_d;
    logic                    canon_ok_d;
    logic [ADDR_W-1:0]       entry_flags_d, exit_flags_d;
    logic [1:0][SEL_W-1:0]   code_sel_d, stk_sel_d;
    logic                    unused_cfg;

    assign sce_d      = ext_feat_i[EN_BIT];
    assign unused_cfg = ^{ext_feat_i, sel_cfg_i[2*SEL_W-1:0]};

    sxu_canon_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) i_canon (
        .addr_hi  (rcx_i[ADDR_W-1:VA_BITS-1]),
        .canon_ok (canon_ok_d)
    );

    sxu_flag_xform #(.ADDR_W(ADDR_W), .IF_BIT(IF_BIT)) i_flags (
        .cur_flags   (flags_i),
        .entry_mask  (flag_mask_i),
        .saved_flags (r11_i),
        .entry_flags (entry_flags_d),
        .exit_flags  (exit_flags_d)
    );

    sxu_sel_pick #(.SEL_W(SEL_W), .SS_STEP(SS_STEP)) i_sel (
        .sel_hi   (sel_cfg_i[CFG_W-1:2*SEL_W]),
        .code_sel (code_sel_d),
        .stk_sel  (stk_sel_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        st_d.vec   = 8'd0;
        if (op_valid_i) begin
            case (sxu_op_e'(op_kind_i))
                OP_CALL: begin
                    if (!sce_d) begin
                        st_d.fault = 1'b1;
                        st_d.vec   = VEC_INV_OP;
                    end else begin
                        st_d.rcx_val = next_ip_i;
                        st_d.r11_val = flags_i;
                        st_d.we      = 1'b1;
                        st_d.ip      = entry_addr_i;
                        st_d.flags   = entry_flags_d;
                        st_d.cs      = code_sel_d[0];
                        st_d.ss      = stk_sel_d[0];
                        st_d.cpl     = CPL_KERN;
                        st_d.done    = 1'b1;
                    end
                end
                OP_RET: begin
                    if (!sce_d) begin
                        st_d.fault = 1'b1;
                        st_d.vec   = VEC_INV_OP;
                    end else if ((st_q.cpl != CPL_KERN) || !canon_ok_d) begin
                        st_d.fault = 1'b1;
                        st_d.vec   = VEC_PROT;
                    end else begin
                        st_d.ip    = rcx_i;
                        st_d.flags = exit_flags_d;
                        st_d.cs    = code_sel_d[1];
                        st_d.ss    = stk_sel_d[1];
                        st_d.cpl   = CPL_USER;
                        st_d.done  = 1'b1;
                    end
                end
                OP_SWAP: begin
                    if (st_q.cpl != CPL_KERN) begin
                        st_d.fault = 1'b1;
                        st_d.vec   = VEC_PROT;
                    end else begin
                        st_d.gs   = kgs_base_i;
                        st_d.kgs  = gs_base_i;
                        st_d.done = 1'b1;
                    end
                end
                default: begin
                    st_d.fault = 1'b1;
                    st_d.vec   = VEC_INV_OP;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ip_o         = st_q.ip;
    assign flags_o      = st_q.flags;
    assign cs_o         = st_q.cs;
    assign ss_o         = st_q.ss;
    assign cpl_o        = st_q.cpl;
    assign rcx_wr_o     = st_q.rcx_val;
    assign r11_wr_o     = st_q.r11_val;
    assign scratch_we_o = st_q.we;
    assign gs_base_o    = st_q.gs;
    assign kgs_base_o   = st_q.kgs;
    assign done_o       = st_q.done;
    assign fault_o      = st_q.fault;
    assign fault_vec_o  = st_q.vec;

    // ---------------- assertions ----------------
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> (done_o ^ fault_o));

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> (!done_o && !fault_o));

    assert_fault_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(cs_o) && $stable(ss_o) && $stable(cpl_o) && $stable(ip_o)));

    assert_call_to_kernel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == OP_CALL) |=> (done_o |-> (cpl_o == CPL_KERN && ss_o == cs_o + SEL_W'(SS_STEP))));

    assert_ret_canonical_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == OP_RET) |=> (done_o |-> (ip_o[ADDR_W-1:VA_BITS-1] == '0 || ip_o[ADDR_W-1:VA_BITS-1] == '1)));

    assert_ret_if_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == OP_RET) |=> (done_o |-> (flags_o[IF_BIT] && cpl_o == CPL_USER)));

    assert_swap_kernel_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == OP_SWAP && cpl_o != CPL_KERN) |=> (fault_o && fault_vec_o == VEC_PROT));

    assert_vec_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> (fault_vec_o == 8'd0));

endmodule

// File: tb/test_syscall_xfer_unit.sv
`timescale 1ns/1ps
module test_syscall_xfer_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [63:0] next_ip = '0, flags = '0, rcx = '0, r11 = '0, efer = '0;
    logic [63:0] sel = '0, entry = '0, mask = '0, gs_in = '0, kgs_in = '0;

    logic [63:0] ip_o, flags_o, rcx_wr, r11_wr, gs_o, kgs_o;
    logic [15:0] cs_o, ss_o;
    logic [1:0]  cpl_o;
    logic        we_o, done_o, fault_o;
    logic [7:0]  vec_o;

    always #5 clk = ~clk;

    syscall_xfer_unit i_syscall_xfer_unit (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
        .next_ip_i(next_ip), .flags_i(flags), .rcx_i(rcx), .r11_i(r11),
        .ext_feat_i(efer), .sel_cfg_i(sel), .entry_addr_i(entry),
        .flag_mask_i(mask), .gs_base_i(gs_in), .kgs_base_i(kgs_in),
        .ip_o(ip_o), .flags_o(flags_o), .cs_o(cs_o), .ss_o(ss_o), .cpl_o(cpl_o),
        .rcx_wr_o(rcx_wr), .r11_wr_o(r11_wr), .scratch_we_o(we_o),
        .gs_base_o(gs_o), .kgs_base_o(kgs_o), .done_o(done_o),
        .fault_o(fault_o), .fault_vec_o(vec_o)
    );

    typedef struct packed {
        logic        done, fault, we;
        logic [7:0]  vec;
        logic [63:0] ip, flags, rcx, r11, gs, kgs;
        logic [15:0] cs, ss;
        logic [1:0]  cpl;
    } exp_t;

    exp_t  q[$];
    string qtag[$];
    exp_t  m;          // reference state
    int    n_chk = 0;
    int    n_fail = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_canon(logic [63:0] a);
        return {{16{a[47]}}, a[47:0]} == a;
    endfunction

    // driver: applies one op, pushes the expected result
    task automatic do_op(string tag, logic [1:0] kind, logic [63:0] e_feat,
                         logic [63:0] nip, logic [63:0] fl, logic [63:0] c,
                         logic [63:0] s11, logic [63:0] msk, logic [63:0] ent,
                         logic [63:0] g, logic [63:0] kg);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; efer = e_feat; next_ip = nip;
        flags = fl; rcx = c; r11 = s11; mask = msk; entry = ent;
        gs_in = g; kgs_in = kg;
        e = m;
        e.done = 0; e.fault = 0; e.we = 0; e.vec = 0;
        if (kind == 2'd3 || (kind != 2'd2 && !e_feat[8])) begin
            e.fault = 1; e.vec = 8'd6;
        end else if (kind == 2'd0) begin
            e.done = 1; e.we = 1; e.rcx = nip; e.r11 = fl;
            e.ip = ent; e.flags = fl & ~msk;
            e.cs = sel[47:32]; e.ss = sel[47:32] + 16'd8; e.cpl = 2'd0;
        end else if (kind == 2'd1) begin
            if (m.cpl == 2'd3 || !is_canon(c)) begin
                e.fault = 1; e.vec = 8'd13;
            end else begin
                e.done = 1; e.ip = c; e.flags = s11 | 64'h200;
                e.cs = sel[63:48]; e.ss = sel[63:48] + 16'd8; e.cpl = 2'd3;
            end
        end else begin
            if (m.cpl == 2'd3) begin
                e.fault = 1; e.vec = 8'd13;
            end else begin
                e.done = 1; e.gs = kg; e.kgs = g;
            end
        end
        m = e;
        q.push_back(e);
        qtag.push_back(tag);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // monitor: results are due 2 ns after the edge that follows the strobe
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (q.size() > 0) begin
                    e = q.pop_front();
                    t = qtag.pop_front();
                    chk("R10", {t, " done"}, 64'(done_o), 64'(e.done));
                    chk("R10", {t, " fault"}, 64'(fault_o), 64'(e.fault));
                    chk(t, "fault_vec", 64'(vec_o), 64'(e.vec));
                    chk(t, "ip", ip_o, e.ip);
                    chk(t, "flags", flags_o, e.flags);
                    chk(t, "cs", 64'(cs_o), 64'(e.cs));
                    chk(t, "ss", 64'(ss_o), 64'(e.ss));
                    chk(t, "cpl", 64'(cpl_o), 64'(e.cpl));
                    chk(t, "scratch_we", 64'(we_o), 64'(e.we));
                    if (e.we) begin
                        chk(t, "rcx_wr", rcx_wr, e.rcx);
                        chk(t, "r11_wr", r11_wr, e.r11);
                    end
                    chk(t, "gs", gs_o, e.gs);
                    chk(t, "kgs", kgs_o, e.kgs);
                end else begin
                    chk("R10", "idle done|fault", 64'(done_o | fault_o), 64'd0);
                end
            end
        end
    end

    initial begin
        #(20000 * 10);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    localparam logic [63:0] EN  = 64'hD01;
    localparam logic [63:0] ENT = 64'hFFFF_FFFF_8100_0000;

    initial begin
        m = '0;
        sel = 64'h0023_0010_0000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "ip", ip_o, 64'd0);
        chk("R11", "cpl", 64'(cpl_o), 64'd0);
        chk("R11", "done|fault|we", 64'({done_o, fault_o, we_o}), 64'd0);
        chk("R11", "cs", 64'(cs_o), 64'd0);

        do_op("R1", 2'd0, 64'h0, 64'h1000, 64'h246, 0, 0, 64'h47700, ENT, 0, 0);
        do_op("R1", 2'd1, 64'hC01, 0, 0, 64'h4000, 64'h2, 0, 0, 0, 0);
        do_op("R1", 2'd3, 64'h500, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R8", 2'd2, EN, 0, 0, 0, 0, 0, 0, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD);
        do_op("R5 R6", 2'd1, EN, 0, 0, 64'h0000_7FFF_FFFF_F000, 64'h46, 0, 0, 0, 0);
        do_op("R9", 2'd1, EN, 0, 0, 64'h5000, 64'h202, 0, 0, 0, 0);
        do_op("R9", 2'd2, EN, 0, 0, 0, 0, 0, 0, 64'h5, 64'h6);
        do_op("R2 R3 R4", 2'd0, EN, 64'h40_1000, 64'h47FD7, 0, 0, 64'h47700, ENT, 0, 0);
        do_op("R7", 2'd1, EN, 0, 0, 64'h0000_8000_0000_0000, 64'h3, 0, 0, 0, 0);
        do_op("R7", 2'd1, EN, 0, 0, 64'hFFFF_0000_0000_0000, 64'h3, 0, 0, 0, 0);
        do_op("R5 R6", 2'd1, EN, 0, 0, 64'hFFFF_8000_0000_1000, 64'h0, 0, 0, 0, 0);
        do_op("R2 R3", 2'd0, EN, 64'hDEAD_BEE0, 64'hFFFF, 0, 0, 64'h0, 64'h1234_5678, 0, 0);
        do_op("R8", 2'd2, EN, 0, 0, 0, 0, 0, 0, 64'h77, 64'h88);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule